// File: doc/BRIEF.md
# Adaptive Gain Mode Controller

This block chooses how many power switches the regulator's switch controller may flip in one clock cycle. It watches the single-bit output voltage comparison, which the regulator samples on every rising clock edge, together with two window flags that report an output overshoot or undershoot. It produces a 2-bit step-size code: gain 1 for steady operation, gain 2 while the output settles, and gain 3 for an aggressive response to a large excursion.

Steady operation is recognised by the limit cycle. Once the loop has settled, the comparison bit flips back and forth. The block XORs the sampled bit with a copy of itself taken half a clock period later. When the sampled bit has changed, the XOR is high, and this clears a set/reset mode latch. The cleared latch means "steady", and the block selects gain 1. If the bit stays unchanged for a programmable run of consecutive edges, the latch sets again and the controller leaves steady mode. The two window flags pass through a two-flop synchronizer, are OR-ed together, and are gated by the latch. This makes the excursion indicator low whenever the block is in steady mode.

Top module: `gain_mode_ctrl`

## Requirements
- R1: While `rst_i` is high at a rising edge, the outputs after that edge are `gain_o` = 2'b01, `boost_o` = 0 and `excur_o` = 0.
- R2: The gain code follows the two indicators on every cycle: `boost_o`=0 gives 2'b01 (gain 1), `boost_o`=1 with `excur_o`=0 gives 2'b10 (gain 2), and both high give 2'b11 (gain 3).
- R3: `excur_o` is never high while `boost_o` is low, so both indicators are low in steady mode.
- R4: If the value of `cmp_i` sampled at rising edge k differs from the value sampled at edge k-1, then `boost_o` is low after edge k+1. `boost_o` falls only for this reason.
- R5: `boost_o` goes high after the QUIET_LEN-th consecutive edge (default 4) at which no change of the sampled `cmp_i` is seen. After reset the first edge already counts, with the sampled bit compared against 0. A change restarts the count from zero. Once high, `boost_o` stays high until a change is seen.
- R6: `excur_o` after edge k equals `boost_o` after edge k AND (`ovr_i` OR `und_i` as sampled at edge k-1). The flags pass through two flip-flop stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock; the comparison is sampled on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| cmp_i | input | 1 | Output voltage comparison bit (1 = output below target) |
| ovr_i | input | 1 | Overshoot window flag, asynchronous |
| und_i | input | 1 | Undershoot window flag, asynchronous |
| boost_o | output | 1 | Out-of-steady-state indicator (latch output) |
| excur_o | output | 1 | Transient-detect indicator |
| gain_o | output | 2 | Step-size code: 01 gain 1, 10 gain 2, 11 gain 3 |

## Verification
On every cycle, the bound checker enforces the following:
- the consistency of the gain code with the two indicators;
- the rule that the excursion indicator stays low in steady mode;
- the two-edge latency from a change of the comparison bit to the drop of `boost_o`;
- the two-edge flag path into `excur_o`.

It also checks that every rise or fall of `boost_o` follows a matching quiet or changed sample. Some behaviour can only be shown by the bench's scenarios:
- that the latch needs the full run of QUIET_LEN quiet edges, and that a run broken after three quiet edges does not set it;
- that the count restarts after reset;
- that the flags are ignored while the block is steady.

// File: rtl/gmc_pkg.sv
package gmc_pkg;

    // Step-size code handed to the switch controller
    typedef enum logic [1:0] {
        GAIN_STEADY = 2'b01,
        GAIN_SETTLE = 2'b10,
        GAIN_FAST   = 2'b11
    } gain_e;

    // Mode carried from the latch/flag logic to the encoder
    typedef struct packed {
        logic boost;   // latch set: out of steady state
        logic excur;   // excursion seen while out of steady state
    } mode_t;

    localparam int DEF_QUIET_LEN   = 4;
    localparam int DEF_SYNC_STAGES = 2;

    function automatic gain_e pick_gain(input mode_t m);
        gain_e g;
        if (!m.boost)      g = GAIN_STEADY;
        else if (m.excur)  g = GAIN_FAST;
        else               g = GAIN_SETTLE;
        return g;
    endfunction

endpackage

// File: rtl/gmc_flag_sync.sv
module gmc_flag_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (rst_i) chain[s] <= '0;
                else       chain[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (rst_i) chain[s] <= '0;
                else       chain[s] <= chain[s-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/gmc_toggle_det.sv
// Samples the comparison bit on the rising edge, keeps a copy taken half a
// period later on the falling edge, and captures their XOR on that same
// falling edge so the rising-edge logic sees a clean "changed" flag.
module gmc_toggle_det (
    input  logic clk_i,
    input  logic rst_i,
    input  logic cmp_i,
    output logic tog_o
);

    logic samp_q;   // rising-edge sample
    logic half_q;   // half-cycle delayed copy
    logic tog_q;    // XOR of the two, held for the next rising edge

    always_ff @(posedge clk_i) begin
        if (rst_i) samp_q <= 1'b0;
        else       samp_q <= cmp_i;
    end

    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            half_q <= 1'b0;
            tog_q  <= 1'b0;
        end else begin
            half_q <= samp_q;
            tog_q  <= samp_q ^ half_q;
        end
    end

    assign tog_o = tog_q;

endmodule

// File: rtl/gmc_mode_latch.sv
// Set/reset mode latch. A seen change resets it at once; a run of
// QUIET_LEN consecutive quiet edges sets it.
module gmc_mode_latch #(
    parameter int QUIET_LEN = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tog_i,
    output logic boost_o
);

    localparam int CW = (QUIET_LEN < 2) ? 1 : $clog2(QUIET_LEN);
    localparam logic [CW-1:0] QMAX = CW'(QUIET_LEN - 1);

    logic [CW-1:0] run_q;
    logic          boost_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q   <= '0;
            boost_q <= 1'b0;
        end else if (tog_i) begin
            run_q   <= '0;
            boost_q <= 1'b0;
        end else if (run_q >= QMAX) begin
            run_q   <= QMAX;
            boost_q <= 1'b1;
        end else begin
            run_q   <= run_q + 1'b1;
        end
    end

    assign boost_o = boost_q;

endmodule

// File: rtl/gain_mode_ctrl.sv
module gain_mode_ctrl
    import gmc_pkg::*;
#(
    parameter int QUIET_LEN   = DEF_QUIET_LEN,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       cmp_i,
    input  logic       ovr_i,
    input  logic       und_i,
    output logic       boost_o,
    output logic       excur_o,
    output logic [1:0] gain_o
);

    logic       tog;
    logic       boost;
    logic [1:0] flags_s;
    mode_t      mode;

    gmc_toggle_det u_tog (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .cmp_i (cmp_i),
        .tog_o (tog)
    );

    gmc_mode_latch #(.QUIET_LEN(QUIET_LEN)) u_latch (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tog_i   (tog),
        .boost_o (boost)
    );

    gmc_flag_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({ovr_i, und_i}),
        .q_o   (flags_s)
    );

    always_comb begin
        mode.boost = boost;
        mode.excur = boost & (|flags_s);
    end

    assign boost_o = mode.boost;
    assign excur_o = mode.excur;
    assign gain_o  = pick_gain(mode);

endmodule

// File: rtl/gain_mode_ctrl_chk.sv
module gain_mode_ctrl_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic       cmp_i,
    input logic       ovr_i,
    input logic       und_i,
    input logic       boost_o,
    input logic       excur_o,
    input logic [1:0] gain_o
);

    // edges since reset released, saturating
    logic [2:0] cyc_q;
    always_ff @(posedge clk_i) begin
        if (rst_i)              cyc_q <= '0;
        else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
    end

    AST_RESET_STATE: assert property (@(posedge clk_i)
        rst_i |=> (gain_o == 2'b01 && !boost_o && !excur_o)); // R1

    AST_GAIN_STEADY: assert property (@(posedge clk_i) disable iff (rst_i)
        !boost_o |-> gain_o == 2'b01); // R2
    AST_GAIN_SETTLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (boost_o && !excur_o) |-> gain_o == 2'b10); // R2
    AST_GAIN_FAST: assert property (@(posedge clk_i) disable iff (rst_i)
        (boost_o && excur_o) |-> gain_o == 2'b11); // R2

    AST_STEADY_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        excur_o |-> boost_o); // R3

    AST_CHANGE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_q >= 3'd2 && cmp_i != $past(cmp_i)) |=> ##1 !boost_o); // R4
    AST_FALL_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_q >= 3'd5 && $fell(boost_o)) |-> $past(cmp_i, 2) != $past(cmp_i, 3)); // R4

    AST_RISE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_q >= 3'd5 && $rose(boost_o)) |-> $past(cmp_i, 2) == $past(cmp_i, 3)); // R5

    if (SYNC_STAGES == 2) begin : g_flag_chk
        AST_FLAG_PATH: assert property (@(posedge clk_i) disable iff (rst_i)
            cyc_q >= 3'd3 |-> excur_o == (boost_o && ($past(ovr_i, 2) || $past(und_i, 2)))); // R6
    end

endmodule

bind gain_mode_ctrl gain_mode_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .cmp_i   (cmp_i),
    .ovr_i   (ovr_i),
    .und_i   (und_i),
    .boost_o (boost_o),
    .excur_o (excur_o),
    .gain_o  (gain_o)
);

// File: tb/gain_mode_ctrl_bench.sv
`timescale 1ns/1ps
module gain_mode_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp = 1'b0;
    logic       ovr = 1'b0;
    logic       und = 1'b0;
    logic       boost;
    logic       excur;
    logic [1:0] gain;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gain_mode_ctrl u_gain_mode_ctrl (
        .clk_i   (clk),
        .rst_i   (rst),
        .cmp_i   (cmp),
        .ovr_i   (ovr),
        .und_i   (und),
        .boost_o (boost),
        .excur_o (excur),
        .gain_o  (gain)
    );

    // {cmp, ovr, und, expected gain after the edge}; boost and excur follow
    // from the gain code (R2). Rows 1-4 count the first quiet run (R5),
    // 3-8 the flag path (R6), 9-10 a change clearing the latch (R4),
    // 11-15 toggling with flags ignored (R3), 23-28 a run broken after
    // three quiet edges (R5), 29-32 a full run setting the latch (R5).
    localparam int NV = 32;
    localparam logic [4:0] VEC [NV] = '{
        5'b000_01, 5'b000_01, 5'b010_01, 5'b010_11,
        5'b000_11, 5'b000_10, 5'b001_10, 5'b001_11,
        5'b100_11, 5'b100_01, 5'b000_01, 5'b100_01,
        5'b010_01, 5'b110_01, 5'b110_01, 5'b110_01,
        5'b110_01, 5'b110_01, 5'b110_11, 5'b101_11,
        5'b100_11, 5'b100_10, 5'b000_10, 5'b000_01,
        5'b000_01, 5'b000_01, 5'b100_01, 5'b100_01,
        5'b100_01, 5'b100_01, 5'b100_01, 5'b100_10
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag, input logic [1:0] eg);
        check({tag, " R2 gain"}, int'(gain), int'(eg));
        check({tag, " R4/R5 boost"}, int'(boost), int'(eg != 2'b01));
        check({tag, " R3/R6 excur"}, int'(excur), int'(eg == 2'b11));
    endtask

    // drive, then look at the outputs two ns after the next rising edge
    task automatic tick(input logic c, input logic o, input logic u);
        cmp = c; ovr = o; und = u;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check_all("R1 reset", 2'b01);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            tick(VEC[i][4], VEC[i][3], VEC[i][2]);
            check_all($sformatf("vec%0d", i + 1), VEC[i][1:0]);
        end

        // flags raised while latch is set: gain 2, then gain 3 (R6)
        tick(1'b1, 1'b1, 1'b0);
        check_all("R6 flag lag", 2'b10);
        tick(1'b1, 1'b1, 1'b0);
        check_all("R6 flag seen", 2'b11);

        // mid-run reset from gain 3 (R1)
        rst = 1'b1;
        tick(1'b1, 1'b1, 1'b0);
        check_all("R1 mid-run reset", 2'b01);
        rst = 1'b0;

        // quiet count restarts after reset (R5)
        tick(1'b0, 1'b1, 1'b0);
        tick(1'b0, 1'b1, 1'b0);
        tick(1'b0, 1'b1, 1'b0);
        check_all("R5 three quiet after reset", 2'b01);
        tick(1'b0, 1'b1, 1'b0);
        check_all("R5 fourth quiet after reset", 2'b11);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule